// File: doc/BRIEF.md
# Endian Address Munging Bridge

The bridge lets a core whose native byte order is big-endian run software that expects little-endian data. It sits between the core's load/store request port, an internal register bus and an external memory bus. When the little-endian mode input is set, requests for core data accesses go out with their address or their data changed, so that the software sees little-endian order. Requests from the instruction fetch path and from the DMA engine always pass through unmodified.

On the internal register bus the bridge changes only the low two address bits, and only for sub-word sizes. Data bytes stay on their lanes. On the external bus it sends the original address and reverses the four bytes of the 32-bit word, for write data and for returned read data alike. An address decode on the upper address bits picks the bus. The bridge holds one transaction at a time. It accepts no new request until the response to the current one has been returned. A misaligned or unsupported-size request is never issued on either bus and gets an error response.

Top module: `endian_munge_bridge`

## Requirements
- R1: With `le_mode` low, every request reaches its bus with the original address, the original write data, and byte enables computed from the original address. Read data returns unchanged.
- R2: With `le_mode` high, a core data request of size code 2 (4 bytes) keeps its address unchanged on the internal bus.
- R3: With `le_mode` high, a core data request of size code 1 (2 bytes) reaches the internal bus with address bits [1:0] XORed with 2'b10. The upper bits are unchanged.
- R4: With `le_mode` high, a core data request of size code 0 (1 byte) reaches the internal bus with address bits [1:0] XORed with 2'b11. The upper bits are unchanged.
- R5: Instruction fetch requests (source code 1) are never modified in address or data, on either bus.
- R6: On the internal bus, write data and read data pass with no lane reordering. `ib_be` is computed from the final address. Bit i of an enable selects data[8i+7:8i], and byte offset 0 is bits 31:24. Size 4 enables 4'b1111. Size 2 enables 4'b1100 at offset 0 and 4'b0011 at offset 2. Size 1 enables 4'b1000 shifted right by the offset.
- R7: With `le_mode` high, a core data request (source code 0) to the external bus carries the original address and enables computed from it. Its write data has its bytes reversed: byte 0 swaps with byte 3, and byte 1 swaps with byte 2. The bit order inside each byte is kept.
- R8: The read response to such an external core data request returns the bus read data with the same byte reversal. Every other read response returns the bus data as delivered.
- R9: DMA requests (source code 2) are never munged or byte-swapped on either bus.
- R10: A request with size code 3, size 2 on an odd address, or size 4 on an address that is not a multiple of 4 is accepted but not issued. In the cycle after acceptance, the bridge returns `rsp_valid` with `rsp_err` high and `rsp_rdata` zero.
- R11: At most one transaction is in flight. `req_ready` is low from the cycle after an acceptance until the response has been returned, and at most one bus sees a valid request at a time. Addresses whose top 4 bits are 4'hF go to the internal bus, and all others go to the external bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| le_mode | input | 1 | Little-endian mode enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_src | input | 2 | Origin: 0 core data, 1 instruction fetch, 2 DMA |
| req_we | input | 1 | Write when high |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: reserved |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data on big-endian lanes |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Misalignment or size error |
| rsp_rdata | output | 32 | Read data |
| ib_valid | output | 1 | Internal bus request valid |
| ib_ready | input | 1 | Internal bus ready |
| ib_we | output | 1 | Internal bus write |
| ib_addr | output | AW | Internal bus address (munged) |
| ib_be | output | 4 | Internal bus byte enables |
| ib_wdata | output | 32 | Internal bus write data |
| ib_rvalid | input | 1 | Internal bus response valid |
| ib_rdata | input | 32 | Internal bus read data |
| xb_valid | output | 1 | External bus request valid |
| xb_ready | input | 1 | External bus ready |
| xb_we | output | 1 | External bus write |
| xb_addr | output | AW | External bus address |
| xb_be | output | 4 | External bus byte enables |
| xb_wdata | output | 32 | External bus write data |
| xb_rvalid | input | 1 | External bus response valid |
| xb_rdata | input | 32 | External bus read data |

## Verification
The bus request fields depend only on the current request inputs, so the bench compares them in the same cycle that the driver holds the request, before the accepting edge. A bus response raised one edge after acceptance appears on `rsp_valid` in that same cycle. An error response appears in the cycle right after the accepting edge. The bench samples both in that cycle. `req_ready` is checked low in the cycle following every acceptance. Each expected request and response goes into a queue in issue order, so a shifted, missing or extra bus request or response shows up as a mismatch or as a leftover entry at the end.

// File: rtl/endian_munge_bridge.sv
module endian_munge_bridge #(
  parameter int AW = 32,
  parameter int RW = 4,
  parameter logic [RW-1:0] RTAG = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_src,
  input  logic          req_we,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  output logic          ib_valid,
  input  logic          ib_ready,
  output logic          ib_we,
  output logic [AW-1:0] ib_addr,
  output logic [3:0]    ib_be,
  output logic [31:0]   ib_wdata,
  input  logic          ib_rvalid,
  input  logic [31:0]   ib_rdata,
  output logic          xb_valid,
  input  logic          xb_ready,
  output logic          xb_we,
  output logic [AW-1:0] xb_addr,
  output logic [3:0]    xb_be,
  output logic [31:0]   xb_wdata,
  input  logic          xb_rvalid,
  input  logic [31:0]   xb_rdata
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SRC_DATA = 2'd0;

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_B:    return 4'b1000 >> lo;
      SZ_H:    return lo[1] ? 4'b0011 : 4'b1100;
      SZ_W:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  logic busy, err_q, ext_q, swap_q;
  logic [1:0] flip;

  wire in_int  = req_addr[AW-1 -: RW] == RTAG;
  wire core_le = le_mode && (req_src == SRC_DATA);
  wire swap_now = core_le && !in_int;
  wire misal = (req_size == 2'd3) ||
               ((req_size == SZ_H) && req_addr[0]) ||
               ((req_size == SZ_W) && (req_addr[1:0] != 2'b00));

  always_comb begin
    case (req_size)
      SZ_B:    flip = 2'b11;
      SZ_H:    flip = 2'b10;
      default: flip = 2'b00;
    endcase
    if (!core_le) flip = 2'b00;
  end

  assign req_ready = !busy && (misal || (in_int ? ib_ready : xb_ready));
  wire accept = req_valid && req_ready;

  assign ib_valid = req_valid && !busy && !misal && in_int;
  assign ib_we    = req_we;
  assign ib_addr  = {req_addr[AW-1:2], req_addr[1:0] ^ flip};
  assign ib_be    = lanes(req_size, ib_addr[1:0]);
  assign ib_wdata = req_wdata;

  assign xb_valid = req_valid && !busy && !misal && !in_int;
  assign xb_we    = req_we;
  assign xb_addr  = req_addr;
  assign xb_be    = lanes(req_size, req_addr[1:0]);
  assign xb_wdata = swap_now ? bswap(req_wdata) : req_wdata;

  assign rsp_valid = busy && (err_q || (ext_q ? xb_rvalid : ib_rvalid));
  assign rsp_err   = busy && err_q;
  assign rsp_rdata = (!busy || err_q) ? 32'h0 :
                     ext_q ? (swap_q ? bswap(xb_rdata) : xb_rdata) : ib_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err_q  <= 1'b0;
      ext_q  <= 1'b0;
      swap_q <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      err_q  <= misal;
      ext_q  <= !in_int;
      swap_q <= swap_now;
    end else if (rsp_valid) begin
      busy   <= 1'b0;
      err_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/endian_munge_bridge_chk.sv
module endian_munge_bridge_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          le_mode,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_src,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_wdata,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          ib_valid,
  input logic [AW-1:0] ib_addr,
  input logic          xb_valid,
  input logic [AW-1:0] xb_addr,
  input logic [31:0]   xb_wdata
);
  p_one_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ib_valid && xb_valid));

  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_err_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ib_valid && !xb_valid) |=> (rsp_valid && rsp_err));

  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && req_size == 2'd2) |-> (ib_addr == req_addr));

  p_half_munge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && le_mode && req_src == 2'd0 && req_size == 2'd1) |->
    (ib_addr == (req_addr ^ AW'(2))));

  p_byte_munge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && le_mode && req_src == 2'd0 && req_size == 2'd0) |->
    (ib_addr == (req_addr ^ AW'(3))));

  p_fetch_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && req_src == 2'd1) |-> (ib_addr == req_addr));

  p_ext_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_valid && le_mode && req_src == 2'd0) |->
    (xb_addr == req_addr &&
     xb_wdata == {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]}));

  p_dma_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xb_valid && req_src == 2'd2) |-> (xb_addr == req_addr && xb_wdata == req_wdata));
endmodule

bind endian_munge_bridge endian_munge_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .le_mode(le_mode), .req_valid(req_valid),
  .req_ready(req_ready), .req_src(req_src), .req_size(req_size),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .ib_valid(ib_valid), .ib_addr(ib_addr),
  .xb_valid(xb_valid), .xb_addr(xb_addr), .xb_wdata(xb_wdata)
);

// File: tb/endian_munge_bridge_tb_top.sv
module endian_munge_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IRD = 32'hA5B6_C7D8;
  localparam logic [31:0] XRD = 32'h1122_3344;

  logic clk = 0, rst_n = 0, le_mode = 0;
  logic req_valid = 0, req_we = 0;
  logic [1:0] req_src = 0, req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic ib_valid, ib_we, xb_valid, xb_we;
  logic ib_ready = 1, xb_ready = 1, ib_rvalid = 0, xb_rvalid = 0;
  logic [31:0] ib_addr, xb_addr, ib_wdata, xb_wdata;
  logic [3:0] ib_be, xb_be;

  int vectors = 0, misses = 0;

  logic        eb_ext[$];
  logic [31:0] eb_addr[$];
  logic [3:0]  eb_be[$];
  logic [31:0] eb_wd[$];
  string       eb_tag[$];
  logic        er_err[$];
  logic [31:0] er_rd[$];
  string       er_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_munge_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .le_mode(le_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_we(req_we), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_we(ib_we), .ib_addr(ib_addr),
    .ib_be(ib_be), .ib_wdata(ib_wdata), .ib_rvalid(ib_rvalid), .ib_rdata(IRD),
    .xb_valid(xb_valid), .xb_ready(xb_ready), .xb_we(xb_we), .xb_addr(xb_addr),
    .xb_be(xb_be), .xb_wdata(xb_wdata), .xb_rvalid(xb_rvalid), .xb_rdata(XRD)
  );

  always @(posedge clk) begin
    ib_rvalid <= rst_n && ib_valid && ib_ready;
    xb_rvalid <= rst_n && xb_valid && xb_ready;
  end

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [3:0] be_exp(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2) return 4'b1111;
    if (sz == 1) return (lo == 0) ? 4'b1100 : 4'b0011;
    return 4'b1000 >> lo;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [1:0] src, input logic we,
                       input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    logic mis, intr, act, sw;
    logic [31:0] fa;
    mis  = (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0);
    intr = (a[31:28] == 4'hF);
    act  = le_mode && src == 0;
    sw   = act && !intr;
    fa   = a;
    if (act && intr) fa[1:0] = a[1:0] ^ ((sz == 0) ? 2'b11 : (sz == 1) ? 2'b10 : 2'b00);
    if (!mis) begin
      eb_ext.push_back(!intr); eb_addr.push_back(fa);
      eb_be.push_back(be_exp(sz, fa[1:0]));
      eb_wd.push_back(sw ? rev(wd) : wd); eb_tag.push_back(tag);
    end
    er_err.push_back(mis);
    er_rd.push_back(mis ? 32'h0 : intr ? IRD : sw ? rev(XRD) : XRD);
    er_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1; req_src = src; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk({tag, " R11 ready low while busy"}, {31'b0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && ((ib_valid && ib_ready) || (xb_valid && xb_ready))) begin
      if (eb_ext.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R10: unexpected bus request addr %h expected none", ib_valid ? ib_addr : xb_addr);
      end else begin
        string t;
        logic e;
        t = eb_tag.pop_front(); e = eb_ext.pop_front();
        chk({t, " R11 bus select"}, {31'b0, xb_valid}, {31'b0, e});
        chk({t, " addr"}, e ? xb_addr : ib_addr, eb_addr.pop_front());
        chk({t, " R6 byte enables"}, {28'b0, e ? xb_be : ib_be}, {28'b0, eb_be.pop_front()});
        chk({t, " wdata"}, e ? xb_wdata : ib_wdata, eb_wd.pop_front());
      end
    end
    if (rst_n && rsp_valid) begin
      if (er_err.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R11: unexpected response %h expected none", rsp_rdata);
      end else begin
        string t;
        t = er_tag.pop_front();
        chk({t, " rsp_err"}, {31'b0, rsp_err}, {31'b0, er_err.pop_front()});
        chk({t, " rsp_rdata"}, rsp_rdata, er_rd.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  localparam logic [31:0] IB = 32'hF000_0040;
  localparam logic [31:0] XB = 32'h0000_1000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R11 reset ready", {31'b0, req_ready}, 32'h1);
    chk("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R11 reset bus idle", {30'b0, ib_valid, xb_valid}, 32'h0);

    le_mode = 0;
    issue("R1 off byte int", 0, 1, 0, IB + 1, 32'h00AB_0000);
    issue("R1 off half ext", 0, 1, 1, XB + 2, 32'h0000_BEEF);
    issue("R1 off word ext read", 0, 0, 2, XB, 32'h0);

    le_mode = 1;
    issue("R2 word int", 0, 1, 2, IB + 4, 32'hDEAD_BEEF);
    issue("R3 half int off0", 0, 1, 1, IB, 32'h0000_1234);
    issue("R3 half int off2", 0, 0, 1, IB + 2, 32'h0);
    for (int k = 0; k < 4; k++)
      issue("R4 R6 byte int", 0, 1, 0, IB + 8 + k, 32'h5A5A_5A5A);
    issue("R7 byte ext", 0, 1, 0, XB + 1, 32'h0011_2233);
    issue("R7 half ext", 0, 1, 1, XB + 2, 32'hCAFE_F00D);
    issue("R8 word ext read", 0, 0, 2, XB + 8, 32'h0);
    issue("R5 fetch int", 1, 0, 2, IB + 12, 32'h0);
    issue("R5 fetch ext", 1, 0, 2, XB + 16, 32'h0);
    issue("R9 dma byte int", 2, 1, 0, IB + 1, 32'h0077_0000);
    issue("R9 dma word ext", 2, 1, 2, XB + 4, 32'h0102_0304);
    issue("R9 dma ext read", 2, 0, 2, XB + 12, 32'h0);
    issue("R10 half odd", 0, 1, 1, XB + 3, 32'h0);
    issue("R10 word off2", 0, 0, 2, IB + 2, 32'h0);
    issue("R10 size3", 2, 1, 3, XB, 32'h0);
    issue("R8 R11 after err", 0, 0, 2, XB + 20, 32'h0);

    repeat (4) @(negedge clk);
    chk("R11 all bus requests seen", eb_ext.size(), 0);
    chk("R11 all responses seen", er_err.size(), 0);
    finish_run();
  end
endmodule